// File: doc/BRIEF.md
# Multi-Channel Temperature Alarm Monitor

This block watches four temperature channels against thresholds that software sets. A programmable interval counter produces a scan tick. On each tick the block walks the channels in ascending index order. For every eligible channel it issues one read request and waits for the matching reading. Each reading is checked against that channel's low limit, its high limit and its high-limit hysteresis. The result updates a sticky low alarm and a sticky high alarm. Whenever either alarm flips, the block raises a one-cycle notify pulse for that channel and that alarm.

Thresholds go in through a one-cycle write port and come back through a combinational read port. Every written value is limited to the range 0 to 130. The temperature source sits behind two valid/ready streams. A request stream carries the channel index. A response stream carries the reading and an error flag. Only one request is ever outstanding.

The request side follows the usual back-pressure rule: once `req_valid` rises, `req_valid` and `req_ch` hold until `req_ready` is seen. The response side accepts a beat only while `rsp_ready` is high, which is exactly while a request is in flight. The source may stall for any number of cycles on either stream. The `suspend` input freezes the interval counter. It does not abort a scan that is already running.

Top module: `thermal_watch`

## Requirements
- R1: After reset all alarm flags and notify pulses are 0, `req_valid` is 0, `rsp_ready` is 0 and every threshold reads back as 0.
- R2: A write with `wr_sel` 0 stores the low limit, 1 stores the high limit and 2 stores the hysteresis of channel `wr_ch`. Any value above 130 is stored as 130. `wr_sel` 3 stores nothing and reads back 0. `rd_data` shows the value selected by `rd_ch`/`rd_sel` in the same cycle.
- R3: The interval counter runs only while some channel has a nonzero low or high limit. While it runs, scan ticks come every `interval` cycles, with 0 treated as 1. When every low and high limit is 0, no request is issued.
- R4: While `suspend` is 1 the interval counter holds its count and produces no tick. When `suspend` returns to 0 counting resumes, provided some limit is still nonzero.
- R5: Within a scan, requests go out in ascending channel order. At most one request is outstanding at a time. A tick that arrives while a scan is in progress is dropped.
- R6: A channel whose low and high limits are both 0, or whose high limit is below its low limit, gets no request during a scan.
- R7: When the low limit is nonzero, a good reading sets the low alarm if the temperature is strictly below the limit and clears it otherwise. When the low limit is 0 the low alarm holds.
- R8: When the high limit is nonzero, a good reading sets the high alarm if the temperature is strictly above the limit. It clears the alarm if the temperature is strictly below (high limit minus hysteresis), where a negative difference never clears. Any other reading leaves the alarm as it was.
- R9: A response with `rsp_err` 1, or with a reading equal to 150, leaves both alarms of that channel unchanged.
- R10: `min_note[i]` or `max_note[i]` is 1 for exactly the one cycle after the edge at which alarm i changes value, and is 0 at all other times.
- R11: `req_valid` and `req_ch` hold steady until `req_ready` is seen. `rsp_ready` is 1 only while a request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| suspend | input | 1 | Freezes the interval counter |
| interval | input | 16 | Scan period in cycles (0 acts as 1) |
| wr_en | input | 1 | Threshold write strobe |
| wr_ch | input | 2 | Channel to write |
| wr_sel | input | 2 | 0 low, 1 high, 2 hysteresis, 3 none |
| wr_data | input | 8 | Value to write (clamped to 130) |
| rd_ch | input | 2 | Channel to read |
| rd_sel | input | 2 | Field to read, same coding as `wr_sel` |
| rd_data | output | 8 | Selected threshold value |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Source accepts request |
| req_ch | output | 2 | Channel being requested |
| rsp_valid | input | 1 | Reading valid |
| rsp_ready | output | 1 | Block waits for a reading |
| rsp_temp | input | 8 | Reading (150 means failure) |
| rsp_err | input | 1 | Source reports read failure |
| min_alarm | output | 4 | Sticky low alarms |
| max_alarm | output | 4 | Sticky high alarms |
| min_note | output | 4 | Low-alarm change pulses |
| max_note | output | 4 | High-alarm change pulses |

## Verification
The bench sweeps one channel's reading up and down one degree at a time across both limits and the hysteresis band, including the exact values 40, 70 and 80. A design with an off-by-one compare would set or clear an alarm one degree early, and one that ignored hysteresis would clear the high alarm straight after it falls back to the limit. Other tests cover:
- a hysteresis larger than the high limit, where a design with unsigned wrap-around would clear the alarm at once;
- a high limit below the low limit, which must cause no request;
- the 150 reading and the error flag, which must leave the flags unchanged;
- the clamp at 130;
- the scan stopping when every limit is cleared and while suspended, and its period and channel order once it runs.

// File: rtl/thermal_watch_pkg.sv
package thermal_watch_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_HYST = 2'd2,
    SEL_NONE = 2'd3
  } thr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_REQ,
    ST_WAIT
  } scan_state_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thermal_watch_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TW     = 8,
  parameter int LIMIT  = 130,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_sel,
  input  logic [TW-1:0]   wr_data,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [1:0]      rd_sel,
  output logic [TW-1:0]   rd_data,
  output logic [TW-1:0]   lo_q   [NUM_CH],
  output logic [TW-1:0]   hi_q   [NUM_CH],
  output logic [TW-1:0]   hyst_q [NUM_CH],
  output logic            any_active
);
  localparam logic [TW-1:0] CAP = TW'(LIMIT);

  logic [TW-1:0] wr_clamped;
  assign wr_clamped = (wr_data > CAP) ? CAP : wr_data;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g]   <= '0;
        hi_q[g]   <= '0;
        hyst_q[g] <= '0;
      end else if (wr_en && wr_ch == CH_W'(g)) begin
        case (thr_sel_e'(wr_sel))
          SEL_LO:   lo_q[g]   <= wr_clamped;
          SEL_HI:   hi_q[g]   <= wr_clamped;
          SEL_HYST: hyst_q[g] <= wr_clamped;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (thr_sel_e'(rd_sel))
      SEL_LO:   rd_data = lo_q[rd_ch];
      SEL_HI:   rd_data = hi_q[rd_ch];
      SEL_HYST: rd_data = hyst_q[rd_ch];
      default:  rd_data = '0;
    endcase
  end

  always_comb begin
    any_active = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (lo_q[i] != '0 || hi_q[i] != '0) any_active = 1'b1;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = (period == '0) ? '0 : period - CNT_W'(1);
  assign tick = run && !hold && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt_q <= '0;
    else if (!hold)      cnt_q <= (cnt_q >= last) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/alarm_eval.sv
module alarm_eval #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lo,
  input  logic [TW-1:0] hi,
  input  logic [TW-1:0] hyst,
  input  logic          cur_lo,
  input  logic          cur_hi,
  output logic          nxt_lo,
  output logic          nxt_hi
);
  logic signed [TW+1:0] clear_pt;
  logic signed [TW+1:0] temp_s;

  assign clear_pt = $signed({2'b00, hi}) - $signed({2'b00, hyst});
  assign temp_s   = $signed({2'b00, temp});

  always_comb begin
    nxt_lo = cur_lo;
    if (lo != '0) nxt_lo = (temp < lo);
    nxt_hi = cur_hi;
    if (hi != '0) begin
      if (temp > hi)               nxt_hi = 1'b1;
      else if (temp_s < clear_pt)  nxt_hi = 1'b0;
    end
  end
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
  import thermal_watch_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int TW        = 8,
  parameter int CNT_W     = 16,
  parameter int LIMIT     = 130,
  parameter int FAIL_CODE = 150,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic [CNT_W-1:0]  interval,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [1:0]        wr_sel,
  input  logic [TW-1:0]     wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [1:0]        rd_sel,
  output logic [TW-1:0]     rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_ch,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [TW-1:0]     rsp_temp,
  input  logic              rsp_err,
  output logic [NUM_CH-1:0] min_alarm,
  output logic [NUM_CH-1:0] max_alarm,
  output logic [NUM_CH-1:0] min_note,
  output logic [NUM_CH-1:0] max_note
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [TW-1:0] lo_q [NUM_CH];
  logic [TW-1:0] hi_q [NUM_CH];
  logic [TW-1:0] hyst_q [NUM_CH];
  logic          any_active, tick;

  scan_state_e     state_q;
  logic [CH_W-1:0] cur_q;
  logic            eligible, failed, nxt_lo, nxt_hi;

  thr_regs #(.NUM_CH(NUM_CH), .TW(TW), .LIMIT(LIMIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .lo_q(lo_q), .hi_q(hi_q), .hyst_q(hyst_q), .any_active(any_active)
  );

  interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(any_active), .hold(suspend),
    .period(interval), .tick(tick)
  );

  alarm_eval #(.TW(TW)) u_eval (
    .temp(rsp_temp), .lo(lo_q[cur_q]), .hi(hi_q[cur_q]), .hyst(hyst_q[cur_q]),
    .cur_lo(min_alarm[cur_q]), .cur_hi(max_alarm[cur_q]),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi)
  );

  assign eligible  = (lo_q[cur_q] != '0 || hi_q[cur_q] != '0) &&
                     !(hi_q[cur_q] < lo_q[cur_q]);
  assign failed    = rsp_err || (rsp_temp == TW'(FAIL_CODE));
  assign req_valid = (state_q == ST_REQ);
  assign req_ch    = cur_q;
  assign rsp_ready = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      min_alarm <= '0;
      max_alarm <= '0;
      min_note  <= '0;
      max_note  <= '0;
    end else begin
      min_note <= '0;
      max_note <= '0;
      case (state_q)
        ST_IDLE: if (tick) begin
          cur_q   <= '0;
          state_q <= ST_PICK;
        end
        ST_PICK: begin
          if (eligible)              state_q <= ST_REQ;
          else if (cur_q == LAST_CH) state_q <= ST_IDLE;
          else                       cur_q   <= cur_q + CH_W'(1);
        end
        ST_REQ: if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (!failed) begin
            min_alarm[cur_q] <= nxt_lo;
            max_alarm[cur_q] <= nxt_hi;
            min_note[cur_q]  <= nxt_lo ^ min_alarm[cur_q];
            max_note[cur_q]  <= nxt_hi ^ max_alarm[cur_q];
          end
          if (cur_q == LAST_CH) state_q <= ST_IDLE;
          else begin
            cur_q   <= cur_q + CH_W'(1);
            state_q <= ST_PICK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thermal_watch_chk.sv
module thermal_watch_chk #(
  parameter int NUM_CH    = 4,
  parameter int TW        = 8,
  parameter int LIMIT     = 130,
  parameter int FAIL_CODE = 150,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CH_W-1:0]   req_ch,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [TW-1:0]     rsp_temp,
  input logic              rsp_err,
  input logic [TW-1:0]     rd_data,
  input logic [NUM_CH-1:0] min_alarm,
  input logic [NUM_CH-1:0] max_alarm,
  input logic [NUM_CH-1:0] min_note,
  input logic [NUM_CH-1:0] max_note
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_ch)); // R11

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready); // R5

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_ready) |=> $stable(min_alarm) && $stable(max_alarm)); // R7

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && (rsp_err || rsp_temp == TW'(FAIL_CODE))
    |=> $stable(min_alarm) && $stable(max_alarm)); // R9

  AST_MIN_NOTE: assert property (@(posedge clk) disable iff (!rst_n)
    min_note == (min_alarm ^ $past(min_alarm))); // R10

  AST_MAX_NOTE: assert property (@(posedge clk) disable iff (!rst_n)
    max_note == (max_alarm ^ $past(max_alarm))); // R10

  AST_NOTE_ONE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(min_note | max_note)); // R5

  AST_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data <= TW'(LIMIT)); // R2
endmodule

bind thermal_watch thermal_watch_chk #(
  .NUM_CH(NUM_CH), .TW(TW), .LIMIT(LIMIT), .FAIL_CODE(FAIL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ch(req_ch), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_temp(rsp_temp), .rsp_err(rsp_err), .rd_data(rd_data),
  .min_alarm(min_alarm), .max_alarm(max_alarm),
  .min_note(min_note), .max_note(max_note)
);

// File: tb/test_thermal_watch.sv
module test_thermal_watch;
  logic clk = 0, rst_n = 0, suspend = 0;
  logic [15:0] interval = 16'd20;
  logic wr_en = 0;
  logic [1:0] wr_ch = 0, wr_sel = 0, rd_ch = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic req_valid, req_ready = 1, rsp_valid = 0, rsp_ready, rsp_err = 0;
  logic [1:0] req_ch;
  logic [7:0] rsp_temp = 0;
  logic [3:0] min_alarm, max_alarm, min_note, max_note;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int ch_temp [4];
  bit ch_err [4];
  int served [4];
  int hs_cnt = 0;
  bit pend = 0;
  int pend_ch = 0;
  int last_t0 = -1, gap0 = 0;
  int prev_ch = -1, order_bad = 0;
  bit order_on = 0;
  int min_cnt [4], max_cnt [4];
  int m_lo [4], m_hi [4], m_hy [4];
  bit e_min [4], e_max [4];
  int e_min_cnt [4], e_max_cnt [4];

  thermal_watch i_thermal_watch (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .interval(interval),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_temp(rsp_temp),
    .rsp_err(rsp_err), .min_alarm(min_alarm), .max_alarm(max_alarm),
    .min_note(min_note), .max_note(max_note)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rsp_valid && rsp_ready) served[pend_ch] <= served[pend_ch] + 1;
    if (rst_n && req_valid && req_ready) begin
      hs_cnt <= hs_cnt + 1;
      if (req_ch == 2'd0) begin
        if (last_t0 >= 0) gap0 <= cyc - last_t0;
        last_t0 <= cyc;
      end
      if (order_on && prev_ch >= 0 && int'(req_ch) != (prev_ch + 1) % 4)
        order_bad <= order_bad + 1;
      prev_ch <= int'(req_ch);
    end
  end

  // source model: answers one cycle after each accepted request
  always @(negedge clk) begin
    rsp_valid = 0;
    if (pend) begin
      rsp_valid = 1;
      rsp_temp  = 8'(ch_temp[pend_ch]);
      rsp_err   = ch_err[pend_ch];
      pend = 0;
    end
    if (req_valid && req_ready) begin
      pend = 1;
      pend_ch = int'(req_ch);
    end
    for (int i = 0; i < 4; i++) begin
      if (min_note[i]) min_cnt[i]++;
      if (max_note[i]) max_cnt[i]++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input int val);
    @(posedge clk); #1;
    wr_en = 1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = 8'(val);
    @(posedge clk); #1;
    wr_en = 0;
    if (sel == 0) m_lo[ch] = (val > 130) ? 130 : val;
    if (sel == 1) m_hi[ch] = (val > 130) ? 130 : val;
    if (sel == 2) m_hy[ch] = (val > 130) ? 130 : val;
  endtask

  task automatic rd(input int ch, input int sel, output int v);
    rd_ch = 2'(ch); rd_sel = 2'(sel); #1; v = int'(rd_data);
  endtask

  // one reading on channel ch, then compare flags and pulse counts with the model
  task automatic step(input int ch, input int t, input bit bad, input string req);
    int target;
    @(posedge clk); #1;
    ch_temp[ch] = t; ch_err[ch] = bad;
    target = served[ch] + 1;
    while (served[ch] < target) @(negedge clk);
    if (!bad && t != 150) begin
      bit nmin = e_min[ch], nmax = e_max[ch];
      if (m_lo[ch] != 0) nmin = (t < m_lo[ch]);
      if (m_hi[ch] != 0) begin
        if (t > m_hi[ch]) nmax = 1;
        else if (t < m_hi[ch] - m_hy[ch]) nmax = 0;
      end
      if (nmin != e_min[ch]) e_min_cnt[ch]++;
      if (nmax != e_max[ch]) e_max_cnt[ch]++;
      e_min[ch] = nmin; e_max[ch] = nmax;
    end
    @(negedge clk);
    chk({req, " min flag"}, int'(min_alarm[ch]), int'(e_min[ch]));
    chk({req, " max flag"}, int'(max_alarm[ch]), int'(e_max[ch]));
    chk("R10 min pulses", min_cnt[ch], e_min_cnt[ch]);
    chk("R10 max pulses", max_cnt[ch], e_max_cnt[ch]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int v, s0, h0;
    for (int i = 0; i < 4; i++) begin
      ch_temp[i] = 25; ch_err[i] = 0; served[i] = 0; min_cnt[i] = 0; max_cnt[i] = 0;
      m_lo[i] = 0; m_hi[i] = 0; m_hy[i] = 0; e_min[i] = 0; e_max[i] = 0;
      e_min_cnt[i] = 0; e_max_cnt[i] = 0;
    end
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk("R1 min_alarm", int'(min_alarm), 0);
    chk("R1 max_alarm", int'(max_alarm), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 rsp_ready", int'(rsp_ready), 0);
    rd(3, 1, v); chk("R1 threshold", v, 0);

    // R3: all limits zero -> no requests
    repeat (60) @(posedge clk);
    chk("R3 idle no requests", hs_cnt, 0);

    // R2: clamp and field select
    wr(3, 0, 200); rd(3, 0, v); chk("R2 clamp 200", v, 130);
    wr(3, 0, 130); rd(3, 0, v); chk("R2 value 130", v, 130);
    wr(3, 2, 131); rd(3, 2, v); chk("R2 clamp hyst", v, 130);
    wr(3, 3, 77);  rd(3, 3, v); chk("R2 sel 3 reads 0", v, 0);
    rd(3, 1, v); chk("R2 sel 3 no side effect", v, 0);
    wr(3, 0, 0); wr(3, 2, 0);
    // ch3 had lo=130 > hi=0, so it was skipped (R6)
    chk("R6 ch3 skipped with hi<lo", served[3], 0);

    // R7 R8: sweep channel 0 with lo 40, hi 80, hyst 10
    wr(0, 0, 40); wr(0, 1, 80); wr(0, 2, 10);
    step(0, 0, 0, "R7 cold");
    for (int t = 30; t <= 90; t++) step(0, t, 0, "R8 rising");
    for (int t = 90; t >= 30; t--) step(0, t, 0, "R8 falling");
    step(0, 140, 0, "R8 hot");
    step(0, 75, 0, "R8 in band");

    // R9: failures leave flags alone
    step(0, 150, 0, "R9 sentinel");
    step(0, 10, 1, "R9 err flag");
    step(0, 10, 0, "R7 after fail");

    // R8: hysteresis above high limit never clears
    wr(1, 1, 60); wr(1, 2, 70);
    step(1, 61, 0, "R8 big hyst set");
    step(1, 0, 0, "R8 big hyst hold");
    step(1, 60, 0, "R8 at limit hold");

    // R6: hi below lo -> channel 2 gets no request
    wr(2, 0, 50); wr(2, 1, 30);
    s0 = served[2];
    repeat (100) @(posedge clk);
    chk("R6 hi<lo skipped", served[2], s0);

    // R3: period between channel 0 requests
    repeat (50) @(posedge clk);
    chk("R3 tick period 20", gap0, 20);
    interval = 16'd33;
    repeat (120) @(posedge clk);
    chk("R3 tick period 33", gap0, 33);

    // R4: suspend freezes scanning, resume restarts
    suspend = 1;
    repeat (20) @(posedge clk);
    h0 = hs_cnt;
    repeat (100) @(posedge clk);
    chk("R4 no requests while suspended", hs_cnt, h0);
    suspend = 0;
    repeat (80) @(posedge clk);
    chk("R4 scanning resumes", int'(hs_cnt > h0), 1);

    // R5: all channels active, order 0,1,2,3 even with ticks dropped
    wr(2, 1, 90); wr(3, 1, 90);
    interval = 16'd2;
    repeat (10) @(posedge clk);
    prev_ch = -1; order_on = 1;
    repeat (300) @(posedge clk);
    order_on = 0;
    chk("R5 ascending order", order_bad, 0);
    chk("R5 scans ran", int'(hs_cnt > h0 + 40), 1);
    interval = 16'd20;

    // R11: a stalled request holds
    req_ready = 0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R11 request held while stalled", int'(req_valid), 1);
    chk("R11 no rsp_ready before accept", int'(rsp_ready), 0);
    req_ready = 1;
    repeat (30) @(posedge clk);

    // R3: clearing every limit stops the scan
    for (int i = 0; i < 4; i++) begin wr(i, 0, 0); wr(i, 1, 0); end
    repeat (30) @(posedge clk);
    h0 = hs_cnt;
    repeat (100) @(posedge clk);
    chk("R3 stopped when cleared", hs_cnt, h0);
    wr(1, 1, 100);
    repeat (60) @(posedge clk);
    chk("R3 restart on new limit", int'(hs_cnt > h0), 1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule